// File: doc/BRIEF.md
# Upset-Guarded One-Hot Transfer Controller

This block sequences a simple data transfer through five control phases: waiting, fetching, evaluating, rejecting and emitting. Each phase owns one flip-flop of the state register, so exactly one bit is set whenever the machine is healthy. A chain of exclusive-OR gates checks every cycle that the register holds an odd number of ones. A single flipped bit always leaves an even count. That count selects, through a multiplexer in front of the register, between the ordinary next phase and a fixed recovery pattern. The detection path has no storage of its own, so an upset can never be latched inside the checker itself.

All handshake inputs are synchronous to the controller clock. The phase controls and the error pulse are registered. A test input can flip one chosen state bit for one edge, which makes it possible to exercise detection and recovery from outside the block.

Top module: `ohp_guarded_fsm`

## Requirements
- R1: While `rst_n` is low, and before the first clock edge after it rises, `idle_o` is 1 and `fetch_o`, `eval_o`, `reject_o`, `emit_o` and `upset_o` are 0.
- R2: The phases map one-hot to the state bits: waiting is bit 0, fetching bit 1, evaluating bit 2, rejecting bit 3 and emitting bit 4. The controls taken as {emit_o, reject_o, eval_o, fetch_o, idle_o} show the state pattern, so at most one control is high at any time.
- R3: While waiting, `start_i` high moves the machine to fetching at the next edge. Otherwise it stays waiting.
- R4: While fetching, `data_valid_i` high moves the machine to evaluating. Otherwise it stays fetching.
- R5: Evaluating lasts exactly one cycle. The next phase is rejecting if `data_bad_i` is high and emitting if it is low.
- R6: Rejecting returns to waiting at the next edge unconditionally. Emitting returns to waiting when `send_done_i` is high and otherwise stays emitting.
- R7: A state pattern with even parity (for example 00000 or 10010) is illegal. For every cycle it is held, all five phase controls are 0.
- R8: At the edge that follows an illegal pattern, the register is loaded with the waiting pattern 00001 whatever the handshake inputs are. `upset_o` is 1 for exactly the one cycle after that edge.
- R9: With `inject_i` high and `inject_sel_i` in 0..4, the next edge inverts state bit `inject_sel_i` instead of performing the normal update. With `inject_sel_i` of 5 or more, the state is held unchanged.
- R10: A handshake input that is not consumed by the current phase has no effect. For example, `data_valid_i`, `data_bad_i` and `send_done_i` all high while waiting leave the machine waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a transfer |
| data_valid_i | input | 1 | Fetched data is available |
| data_bad_i | input | 1 | Evaluation found the data unusable |
| send_done_i | input | 1 | Emission has completed |
| inject_i | input | 1 | Flip one state bit at the next edge |
| inject_sel_i | input | 3 | Index of the state bit to flip |
| idle_o | output | 1 | Waiting phase control |
| fetch_o | output | 1 | Fetching phase control |
| eval_o | output | 1 | Evaluating phase control |
| reject_o | output | 1 | Rejecting phase control |
| emit_o | output | 1 | Emitting phase control |
| upset_o | output | 1 | One-cycle pulse when recovery was taken |

## Verification
A corrupted state register shows at the ports within the same cycle it is captured: all phase controls drop to zero, because the outputs are only driven from a legal pattern. One edge later, the waiting control rises together with a single-cycle `upset_o` pulse. If the recovery multiplexer were missing or wrong, the ports would instead show a phase that was never requested, or a machine that stays dark. If the parity chain were wrong, a legal phase would blank or pulse the flag. Injected flips from the fetching and waiting phases, with conflicting handshake inputs during the recovery edge, make each of these faults visible within two cycles.

// File: rtl/ohp_pkg.sv
package ohp_pkg;
  localparam int NS    = 5;
  localparam int IDX_W = $clog2(NS);

  typedef logic [NS-1:0] st_vec_t;

  localparam int B_IDLE = 0;
  localparam int B_GET  = 1;
  localparam int B_PROC = 2;
  localparam int B_BAD  = 3;
  localparam int B_SEND = 4;

  localparam st_vec_t ST_IDLE = 5'b00001;
  localparam st_vec_t ST_GET  = 5'b00010;
  localparam st_vec_t ST_PROC = 5'b00100;
  localparam st_vec_t ST_BAD  = 5'b01000;
  localparam st_vec_t ST_SEND = 5'b10000;

  // legal one-hot patterns carry an odd number of ones
  function automatic logic is_odd(input st_vec_t v);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < NS; i++) acc = acc ^ v[i];
    return acc;
  endfunction

  // one-bit flip mask; an index beyond the register gives an empty mask
  function automatic st_vec_t flip_mask(input logic [IDX_W-1:0] idx);
    st_vec_t m;
    for (int i = 0; i < NS; i++) m[i] = (idx == IDX_W'(i));
    return m;
  endfunction
endpackage

// File: rtl/ohp_parity_chk.sv
module ohp_parity_chk #(
  parameter int W = 5
) (
  input  logic [W-1:0] vec_i,
  output logic         even_o
);
  logic [W-1:0] chain;

  assign chain[0] = vec_i[0];
  generate
    for (genvar g = 1; g < W; g++) begin : g_xor
      assign chain[g] = chain[g-1] ^ vec_i[g];
    end
  endgenerate

  // XNOR at the end of the chain: high when the count of ones is even
  assign even_o = ~chain[W-1];
endmodule

// File: rtl/ohp_next_state.sv
module ohp_next_state
  import ohp_pkg::*;
(
  input  st_vec_t          st_q_i,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic             bad_i,
  input  logic             done_i,
  input  logic             par_err_i,
  input  logic             inj_en_i,
  input  logic [IDX_W-1:0] inj_sel_i,
  output st_vec_t          st_d_o,
  output logic             recover_o
);
  st_vec_t normal_d;

  // Ordinary transitions, written as a priority chain over the state bits.
  // An illegal pattern can land here anyway; the mux below overrides it.
  always_comb begin
    normal_d = ST_IDLE;
    if (st_q_i[B_IDLE])      normal_d = start_i ? ST_GET  : ST_IDLE;
    else if (st_q_i[B_GET])  normal_d = valid_i ? ST_PROC : ST_GET;
    else if (st_q_i[B_PROC]) normal_d = bad_i   ? ST_BAD  : ST_SEND;
    else if (st_q_i[B_BAD])  normal_d = ST_IDLE;
    else if (st_q_i[B_SEND]) normal_d = done_i  ? ST_IDLE : ST_SEND;
  end

  assign recover_o = par_err_i & ~inj_en_i;

  // injection wins, then recovery, then the normal path
  always_comb begin
    if (inj_en_i)       st_d_o = st_q_i ^ flip_mask(inj_sel_i);
    else if (par_err_i) st_d_o = ST_IDLE;
    else                st_d_o = normal_d;
  end
endmodule

// File: rtl/ohp_out_reg.sv
module ohp_out_reg
  import ohp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  st_vec_t st_d_i,
  input  logic    recover_i,
  output st_vec_t ctl_q_o,
  output logic    err_q_o
);
  logic d_legal;
  logic d_even;

  ohp_parity_chk #(.W(NS)) u_chk_d (.vec_i(st_d_i), .even_o(d_even));
  assign d_legal = ~d_even;

  generate
    for (genvar g = 0; g < NS; g++) begin : g_ctl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q_o[g] <= (g == B_IDLE);
        else        ctl_q_o[g] <= st_d_i[g] & d_legal;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q_o <= 1'b0;
    else        err_q_o <= recover_i;
  end

  AST_CTL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_q_o)); // R2
  AST_ERR_SHOWS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q_o |-> (ctl_q_o == ST_IDLE)); // R8
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q_o |=> !err_q_o); // R8
endmodule

// File: rtl/ohp_guarded_fsm.sv
module ohp_guarded_fsm
  import ohp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             data_valid_i,
  input  logic             data_bad_i,
  input  logic             send_done_i,
  input  logic             inject_i,
  input  logic [IDX_W-1:0] inject_sel_i,
  output logic             idle_o,
  output logic             fetch_o,
  output logic             eval_o,
  output logic             reject_o,
  output logic             emit_o,
  output logic             upset_o
);
  st_vec_t st_q;
  st_vec_t st_d;
  st_vec_t ctl_q;
  logic    par_err;
  logic    recover;

  ohp_parity_chk #(.W(NS)) u_chk_q (.vec_i(st_q), .even_o(par_err));

  ohp_next_state u_next (
    .st_q_i   (st_q),
    .start_i  (start_i),
    .valid_i  (data_valid_i),
    .bad_i    (data_bad_i),
    .done_i   (send_done_i),
    .par_err_i(par_err),
    .inj_en_i (inject_i),
    .inj_sel_i(inject_sel_i),
    .st_d_o   (st_d),
    .recover_o(recover)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  ohp_out_reg u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_d_i   (st_d),
    .recover_i(recover),
    .ctl_q_o  (ctl_q),
    .err_q_o  (upset_o)
  );

  assign idle_o   = ctl_q[B_IDLE];
  assign fetch_o  = ctl_q[B_GET];
  assign eval_o   = ctl_q[B_PROC];
  assign reject_o = ctl_q[B_BAD];
  assign emit_o   = ctl_q[B_SEND];

  AST_ILLEGAL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> (ctl_q == '0)); // R7
  AST_RECOVER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !inject_i) |=> (st_q == ST_IDLE)); // R8
  AST_INJ_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (inject_i && (inject_sel_i < IDX_W'(NS))) |=> ($countones(st_q ^ $past(st_q)) == 1)); // R9
  AST_PROC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PROC && !inject_i) |=> (st_q == ST_BAD || st_q == ST_SEND)); // R5
  AST_BAD_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BAD && !inject_i) |=> (st_q == ST_IDLE)); // R6
endmodule

// File: tb/ohp_guarded_fsm_bench.sv
module ohp_guarded_fsm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  // control vector order: {emit, reject, eval, fetch, idle}
  localparam logic [4:0] C_IDLE = 5'b00001;
  localparam logic [4:0] C_GET  = 5'b00010;
  localparam logic [4:0] C_PROC = 5'b00100;
  localparam logic [4:0] C_BAD  = 5'b01000;
  localparam logic [4:0] C_SEND = 5'b10000;
  localparam logic [4:0] C_DARK = 5'b00000;

  localparam int NV = 12;
  // each entry: {start, valid, bad, done, expected controls after the edge}
  localparam logic [8:0] VEC [NV] = '{
    {4'b0000, C_IDLE},  // R3 stay waiting
    {4'b1000, C_GET },  // R3 start
    {4'b0000, C_GET },  // R4 hold
    {4'b0100, C_PROC},  // R4 valid
    {4'b0000, C_SEND},  // R5 good data
    {4'b0000, C_SEND},  // R6 hold emit
    {4'b0001, C_IDLE},  // R6 done
    {4'b1000, C_GET },  // R3
    {4'b0100, C_PROC},  // R4
    {4'b0010, C_BAD },  // R5 bad data
    {4'b0000, C_IDLE},  // R6 reject returns
    {4'b0111, C_IDLE}   // R10 foreign inputs ignored
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, data_valid_i = 1'b0, data_bad_i = 1'b0, send_done_i = 1'b0;
  logic inject_i = 1'b0;
  logic [2:0] inject_sel_i = 3'd0;
  logic idle_o, fetch_o, eval_o, reject_o, emit_o, upset_o;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ohp_guarded_fsm u_ohp_guarded_fsm (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i), .data_valid_i(data_valid_i),
    .data_bad_i(data_bad_i), .send_done_i(send_done_i),
    .inject_i(inject_i), .inject_sel_i(inject_sel_i),
    .idle_o(idle_o), .fetch_o(fetch_o), .eval_o(eval_o),
    .reject_o(reject_o), .emit_o(emit_o), .upset_o(upset_o)
  );

  function automatic logic [4:0] ctl();
    return {emit_o, reject_o, eval_o, fetch_o, idle_o};
  endfunction

  task automatic check(input string req, input logic [4:0] exp_ctl, input logic exp_err);
    checks++;
    if (ctl() !== exp_ctl || upset_o !== exp_err) begin
      errors++;
      $display("FAIL %s: ctl=%b upset=%b expected ctl=%b upset=%b",
               req, ctl(), upset_o, exp_ctl, exp_err);
    end
  endtask

  // drive at negedge, take one edge, sample at the following negedge
  task automatic step(input logic [3:0] hs, input logic inj, input logic [2:0] sel);
    {start_i, data_valid_i, data_bad_i, send_done_i} = hs;
    inject_i = inj;
    inject_sel_i = sel;
    @(posedge clk);
    @(negedge clk);
    {start_i, data_valid_i, data_bad_i, send_done_i} = 4'b0000;
    inject_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: ran %0d cycles expected completion", WATCHDOG);
    finish_run();
  end

  initial begin
    @(negedge clk);
    check("R1 in reset", C_IDLE, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 after release", C_IDLE, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8:5], 1'b0, 3'd0);
      check($sformatf("R2 vector %0d", i), VEC[i][4:0], 1'b0);
    end

    // flip bit 1 while fetching: 00000
    step(4'b1000, 1'b0, 3'd0);
    check("R3 to fetch", C_GET, 1'b0);
    step(4'b0000, 1'b1, 3'd1);
    check("R7 pattern 00000 dark", C_DARK, 1'b0);
    step(4'b0100, 1'b0, 3'd0);
    check("R8 recover despite valid", C_IDLE, 1'b1);
    step(4'b0000, 1'b0, 3'd0);
    check("R8 flag one cycle", C_IDLE, 1'b0);

    // flip bit 4 while fetching: 10010
    step(4'b1000, 1'b0, 3'd0);
    check("R3 to fetch again", C_GET, 1'b0);
    step(4'b0000, 1'b1, 3'd4);
    check("R7 pattern 10010 dark", C_DARK, 1'b0);
    step(4'b0101, 1'b0, 3'd0);
    check("R8 recover from 10010", C_IDLE, 1'b1);

    // out-of-range selector leaves waiting state intact
    step(4'b0000, 1'b1, 3'd6);
    check("R9 selector 6 ignored", C_IDLE, 1'b0);
    step(4'b0000, 1'b1, 3'd5);
    check("R9 selector 5 ignored", C_IDLE, 1'b0);

    // flip bit 0 while waiting, recover with start held
    step(4'b0000, 1'b1, 3'd0);
    check("R9 flip bit 0", C_DARK, 1'b0);
    step(4'b1000, 1'b0, 3'd0);
    check("R8 recover ignores start", C_IDLE, 1'b1);

    // flip bit 2 while waiting gives 00101, also illegal
    step(4'b0000, 1'b1, 3'd2);
    check("R9 flip bit 2", C_DARK, 1'b0);
    step(4'b0000, 1'b0, 3'd0);
    check("R8 recover from 00101", C_IDLE, 1'b1);

    // reset in the middle of a transfer
    step(4'b1000, 1'b0, 3'd0);
    step(4'b0100, 1'b0, 3'd0);
    check("R4 at evaluate", C_PROC, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", C_IDLE, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(4'b0000, 1'b0, 3'd0);
    check("R1 stays waiting", C_IDLE, 1'b0);

    finish_run();
  end
endmodule